// File: doc/BRIEF.md
# Output Buffer Interrupt Arbiter

This block sits between two byte channels of a keyboard/mouse controller, a keyboard channel and an auxiliary (mouse) channel, and the host-visible side of the controller. Each channel raises a data-available level while it holds at least one byte for the host. The arbiter registers both levels into a two-bit pending mask and derives four things from it. It derives the status-register buffer-full flags and their copies in the output port. It derives the two level interrupt lines. It also picks the channel that the next data-port read is served from.

Keyboard data always wins. The auxiliary flag, the auxiliary interrupt and the auxiliary read select are raised only when the auxiliary channel is the only one holding data. A controller mode byte is held in the block and loaded through a write strobe. Its bit 0 enables the keyboard interrupt, its bit 1 enables the auxiliary interrupt, and its bit 4 disables the keyboard interface, which also masks the keyboard interrupt. The other mode bits have no effect here. All outputs are decoded combinationally from the registered mask and mode, so they settle in the cycle after the clock edge that captured a change.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: While reset is asserted and right after it, the pending mask is empty, the mode byte is 0x03, and every output is low.
- R2: Each pending bit (bit 0 keyboard, bit 1 auxiliary) takes the value its channel's data-available input had at the previous rising clock edge.
- R3: The buffer-full status flag is high exactly when at least one pending bit is set.
- R4: The auxiliary buffer-full status flag is high exactly when the pending mask is 2'b10, meaning auxiliary data only.
- R5: The keyboard interrupt is high exactly when keyboard data is pending, mode bit 0 is 1 and mode bit 4 is 0.
- R6: The auxiliary interrupt is high exactly when the pending mask is 2'b10 and mode bit 1 is 1.
- R7: The output-port buffer-full copy equals the buffer-full status flag, and the output-port auxiliary copy equals the auxiliary status flag, in every cycle.
- R8: The read-source select is 1 (auxiliary) only when the pending mask is 2'b10. Otherwise it is 0 (keyboard).
- R9: A write strobe loads the mode byte at the next rising edge. Without the strobe the mode byte holds, whatever the mode data input carries.
- R10: Setting mode bit 4 masks the keyboard interrupt but leaves the buffer-full flags and the read select unchanged. Mode bits 2, 3, 5, 6 and 7 affect no output.
- R11: The two interrupt lines are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kbd_avail_i | input | 1 | Keyboard channel holds data for the host |
| aux_avail_i | input | 1 | Auxiliary channel holds data for the host |
| mode_wr_i | input | 1 | Load strobe for the mode byte |
| mode_data_i | input | 8 | New mode byte |
| stat_obf_o | output | 1 | Status flag: output buffer full |
| stat_aux_obf_o | output | 1 | Status flag: buffer holds auxiliary data |
| oport_obf_o | output | 1 | Output-port copy of the buffer-full flag |
| oport_aux_obf_o | output | 1 | Output-port copy of the auxiliary flag |
| kbd_irq_o | output | 1 | Keyboard interrupt level |
| aux_irq_o | output | 1 | Auxiliary interrupt level |
| rd_sel_aux_o | output | 1 | Data-port read is served by the auxiliary channel |

## Verification
The assertions assume that the data-available inputs and the mode strobe are settled, defined levels at every rising edge. They also assume that nothing is expected of the outputs until the internal reset release has passed through its synchroniser. The stimulus changes every input only on the falling edge, a half period away from capture. It starts checking only after reset has been released for several cycles. Each test sweeps all four pending combinations against a chosen mode byte, so the priority corner, where both channels are pending, is met under every interrupt-enable setting.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
  localparam int SRC_KBD = 0;
  localparam int SRC_AUX = 1;
  localparam int NUM_SRC = 2;

  typedef logic [NUM_SRC-1:0] pend_t;

  localparam pend_t PEND_NONE     = '0;
  localparam pend_t PEND_AUX_ONLY = pend_t'(1 << SRC_AUX);

  typedef struct packed {
    logic obf;
    logic aux_obf;
    logic kbd_irq;
    logic aux_irq;
    logic sel_aux;
  } flags_t;
endpackage

// File: rtl/obuf_rst_sync.sv
module obuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/obuf_pend_reg.sv
module obuf_pend_reg
  import obuf_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pend_t lvl_i,
  output pend_t pend_o
);
  pend_t pend_d;
  pend_t pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      pend_d[g] = lvl_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end

    // R2: each pending bit is the level seen one edge earlier
    p_pend_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pend_q[g] == $past(lvl_i[g]));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/obuf_mode_reg.sv
module obuf_mode_reg #(
  parameter int              MODE_W   = 8,
  parameter logic [MODE_W-1:0] MODE_RST = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_d;
  logic [MODE_W-1:0] mode_q;

  always_comb begin
    mode_d = mode_q;
    if (wr_en_i) mode_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R9: a strobe loads the byte, absence of a strobe holds it
  p_mode_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mode_q == $past(wr_data_i));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mode_q));
endmodule

// File: rtl/obuf_flag_logic.sv
module obuf_flag_logic
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int KIRQ_BIT = 0,
  parameter int AIRQ_BIT = 1,
  parameter int KDIS_BIT = 4
) (
  input  pend_t             pend_i,
  input  logic [MODE_W-1:0] mode_i,
  output flags_t            flags_o
);
  logic any_pend;
  logic aux_sole;
  logic kbd_sel;

  always_comb begin
    any_pend = |pend_i;
    aux_sole = (pend_i == PEND_AUX_ONLY);
    kbd_sel  = pend_i[SRC_KBD];

    flags_o.obf     = any_pend;
    flags_o.aux_obf = aux_sole;
    flags_o.sel_aux = aux_sole;
    flags_o.kbd_irq = kbd_sel && mode_i[KIRQ_BIT] && !mode_i[KDIS_BIT];
    flags_o.aux_irq = aux_sole && mode_i[AIRQ_BIT];
  end
endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int                MODE_W   = 8,
  parameter int                KIRQ_BIT = 0,
  parameter int                AIRQ_BIT = 1,
  parameter int                KDIS_BIT = 4,
  parameter logic [MODE_W-1:0] MODE_RST = 8'h03,
  parameter int                SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_avail_i,
  input  logic              aux_avail_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_data_i,
  output logic              stat_obf_o,
  output logic              stat_aux_obf_o,
  output logic              oport_obf_o,
  output logic              oport_aux_obf_o,
  output logic              kbd_irq_o,
  output logic              aux_irq_o,
  output logic              rd_sel_aux_o
);
  logic              rst_int_n;
  pend_t             lvl;
  pend_t             pend;
  logic [MODE_W-1:0] mode;
  flags_t            flags;

  obuf_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk      (clk),
    .arst_n_i (rst_n),
    .rst_n_o  (rst_int_n)
  );

  always_comb begin
    lvl          = PEND_NONE;
    lvl[SRC_KBD] = kbd_avail_i;
    lvl[SRC_AUX] = aux_avail_i;
  end

  obuf_pend_reg u_pend (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (lvl),
    .pend_o (pend)
  );

  obuf_mode_reg #(.MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (mode_wr_i),
    .wr_data_i (mode_data_i),
    .mode_o    (mode)
  );

  obuf_flag_logic #(
    .MODE_W(MODE_W), .KIRQ_BIT(KIRQ_BIT), .AIRQ_BIT(AIRQ_BIT), .KDIS_BIT(KDIS_BIT)
  ) u_flags (
    .pend_i  (pend),
    .mode_i  (mode),
    .flags_o (flags)
  );

  assign stat_obf_o      = flags.obf;
  assign stat_aux_obf_o  = flags.aux_obf;
  assign oport_obf_o     = flags.obf;
  assign oport_aux_obf_o = flags.aux_obf;
  assign kbd_irq_o       = flags.kbd_irq;
  assign aux_irq_o       = flags.aux_irq;
  assign rd_sel_aux_o    = flags.sel_aux;

  // R3: any captured level shows as buffer full one edge later
  p_obf_set_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kbd_avail_i || aux_avail_i) |=> stat_obf_o);
  p_obf_clr_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!kbd_avail_i && !aux_avail_i) |=> !stat_obf_o && !kbd_irq_o && !aux_irq_o);
  // R4: keyboard data pending suppresses the auxiliary flag
  p_kbd_prio_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    kbd_avail_i |=> !stat_aux_obf_o && !rd_sel_aux_o);
  // R6: auxiliary interrupt needs the auxiliary flag
  p_aux_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    aux_irq_o |-> stat_aux_obf_o && stat_obf_o);
  // R8: read select follows the sole-auxiliary condition
  p_sel_aux_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_avail_i && !kbd_avail_i) |=> rd_sel_aux_o);
  // R10: keyboard disable bit masks the keyboard interrupt
  p_kdis_mask_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode[KDIS_BIT] |-> !kbd_irq_o);
  // R11: interrupts are mutually exclusive
  p_irq_excl_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(kbd_irq_o && aux_irq_o));
endmodule

// File: tb/obuf_irq_arbiter_tb.sv
module obuf_irq_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       kbd_avail, aux_avail, mode_wr;
  logic [7:0] mode_data;
  logic       stat_obf, stat_aux_obf, oport_obf, oport_aux_obf;
  logic       kbd_irq, aux_irq, rd_sel_aux;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obuf_irq_arbiter u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .kbd_avail_i     (kbd_avail),
    .aux_avail_i     (aux_avail),
    .mode_wr_i       (mode_wr),
    .mode_data_i     (mode_data),
    .stat_obf_o      (stat_obf),
    .stat_aux_obf_o  (stat_aux_obf),
    .oport_obf_o     (oport_obf),
    .oport_aux_obf_o (oport_aux_obf),
    .kbd_irq_o       (kbd_irq),
    .aux_irq_o       (aux_irq),
    .rd_sel_aux_o    (rd_sel_aux)
  );

  // {obf, aux_obf, oport_obf, oport_aux, kbd_irq, aux_irq, sel_aux}
  function automatic logic [6:0] model(input logic k, input logic a, input logic [7:0] m);
    logic obf, ao, ki, ai;
    obf = k | a;
    ao  = a & ~k;
    ki  = k & m[0] & ~m[4];
    ai  = ao & m[1];
    return {obf, ao, obf, ao, ki, ai, ao};
  endfunction

  function automatic logic [6:0] observed();
    return {stat_obf, stat_aux_obf, oport_obf, oport_aux_obf, kbd_irq, aux_irq, rd_sel_aux};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    n_vec++;
    if (observed() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b (k=%b a=%b)", tag, observed(), exp, kbd_avail, aux_avail);
    end
  endtask

  task automatic apply(input logic k, input logic a);
    kbd_avail = k;
    aux_avail = a;
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] m);
    mode_wr   = 1'b1;
    mode_data = m;
    @(negedge clk);
    mode_wr   = 1'b0;
    mode_data = ~m;
  endtask

  task automatic sweep(input string tag, input logic [7:0] m);
    for (int i = 0; i < 4; i++) begin
      apply(i[0], i[1]);
      check(tag, model(i[0], i[1], m));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; kbd_avail = 1'b1; aux_avail = 1'b1; mode_wr = 1'b0; mode_data = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 in reset", 7'b0);
    kbd_avail = 1'b0; aux_avail = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 7'b0);
  endtask

  task automatic t_default_mode();
    // R2 R3 R4 R5 R6 R7 R8 with reset mode 0x03
    sweep("R5 R6 default mode", 8'h03);
    apply(1'b1, 1'b1);
    check("R4 R8 both pending keyboard wins", model(1'b1, 1'b1, 8'h03));
    apply(1'b0, 1'b1);
    check("R2 keyboard drops aux takes over", model(1'b0, 1'b1, 8'h03));
    apply(1'b0, 1'b0);
    check("R3 idle clears flags", 7'b0);
  endtask

  task automatic t_kbd_disable();
    write_mode(8'h13);
    sweep("R10 keyboard disabled", 8'h13);
    apply(1'b1, 1'b0);
    check("R10 obf kept while masked", 7'b1010000);
  endtask

  task automatic t_irq_enables();
    write_mode(8'h00);
    sweep("R5 R6 interrupts off", 8'h00);
    write_mode(8'h01);
    sweep("R5 keyboard only enabled", 8'h01);
    write_mode(8'h02);
    sweep("R6 aux only enabled", 8'h02);
  endtask

  task automatic t_other_bits();
    write_mode(8'hEF);
    sweep("R10 unused bits set", 8'hEF);
    write_mode(8'hEC);
    sweep("R10 unused bits no enables", 8'hEC);
  endtask

  task automatic t_mode_hold();
    write_mode(8'h03);
    mode_wr = 1'b0;
    mode_data = 8'h10;
    repeat (3) @(negedge clk);
    apply(1'b1, 1'b0);
    check("R9 mode held without strobe", model(1'b1, 1'b0, 8'h03));
    apply(1'b0, 1'b1);
    check("R9 mode held aux path", model(1'b0, 1'b1, 8'h03));
    kbd_avail = 1'b1; aux_avail = 1'b0;
    write_mode(8'h10);
    check("R9 new mode visible next cycle", model(1'b1, 1'b0, 8'h10));
  endtask

  task automatic t_toggle();
    write_mode(8'h03);
    for (int i = 0; i < 16; i++) begin
      logic k, a;
      k = i[0] ^ i[2];
      a = i[1] | i[3];
      apply(k, a);
      check("R2 R7 R8 R11 toggling", model(k, a, 8'h03));
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_default_mode();
    t_kbd_disable();
    t_irq_enables();
    t_other_bits();
    t_mode_hold();
    t_toggle();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule